// File: doc/BRIEF.md
# Half-Duplex Buffered SPI Master

This block is a register-programmed SPI master that moves up to eight bytes per command through one shared byte buffer. Software fills the low byte of the buffer entries, then writes a command word giving a total byte count and how many of those bytes are outbound. The controller shifts the outbound bytes out first. It then clocks in the remaining bytes from the serial input and stores them in the buffer entries that follow the outbound ones.

A status word reports whether a command is running and how many bytes were received. A sticky completion flag drives an interrupt line. A command may keep its chip select asserted after it finishes, so a long transaction can be built from several commands. The serial clock runs at the system clock divided by twice the divider field. Clock idle level, bit order, chip-select polarity and a short gap after each command are all programmable.

The register port is a plain single-cycle write strobe with a combinational read. It has no back-pressure, because every access completes in the cycle it is presented.

Top module: `hdx_spi_master`

## Requirements
- R1: After reset every register reads 0, `irq` and `spi_oe` are 0, and every chip-select line is at its inactive level (high, since the polarity bit resets to 0).
- R2: Config bit 0 enables the block and is reflected on `spi_oe`. A command written while bit 0 is 0 is ignored and status bit 0 (busy) stays 0.
- R3: A command write (address 0x10) while idle and enabled sets busy from the next cycle. Busy lasts max(1, (16·T + 2·G)·D) cycles, where T is the byte count after limiting, G is config bits 9:8 and D is config bits 28:16 with 0 treated as 1.
- R4: The first X bytes, X being command bits 12:8 limited to T, are sent from buffer entries 0..X-1 (addresses 0x80 + 8·i, bits 7:0). Bits go out MSB first, or LSB first when config bit 4 is 1. The data line is 0 while receive bytes are clocked.
- R5: The remaining T-X bytes are sampled from `spi_miso` on the edge that leaves the idle level and are written into entries X..T-1, using the same bit order. Status bits 12:8 then read T-X. The count in command bits 4:0 is limited to 8, and X=0 gives a receive-only command.
- R6: Config bit 1 set makes the serial clock idle low, otherwise it idles high. Each byte gives exactly 8 clock pulses.
- R7: Command bits 21:20 select the chip-select line. Config bit 7 makes the asserted level high. The line is asserted during shifting and released after the last bit unless command bit 16 is set, in which case it stays asserted.
- R8: A command write while busy is ignored and does not change the command in progress.
- R9: Completion sets status bit 1 and `irq`. Writing status (0x08) with bit 1 set clears them.
- R10: A buffer write while busy is stored and can be read back, but it does not change the byte currently being shifted out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational on reg_addr) |
| spi_sclk | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |
| spi_cs | output | 4 | Chip-select lines, one per device |
| spi_oe | output | 1 | Pin drive enable; 0 means the pins are tristated |
| irq | output | 1 | Completion interrupt |

## Verification
The bench builds the block with its default values: an eight-entry buffer, four chip-select lines and a 13-bit divider. It programs divider values 0 to 3, so that even full eight-byte commands with the longest gap finish within a few hundred cycles. Because the command count field is five bits wide against an eight-entry buffer, counts above eight are reachable, and so the limiting of both counts can be exercised. A transmit count larger than the total also comes into reach in the same random sweep.

// File: rtl/hdx_spi_pkg.sv
package hdx_spi_pkg;

  localparam int CLKDIV_W = 13;

  localparam logic [7:0] ADR_CFG  = 8'h00;
  localparam logic [7:0] ADR_STAT = 8'h08;
  localparam logic [7:0] ADR_CMD  = 8'h10;
  localparam logic [7:0] ADR_BUF  = 8'h80;

  localparam int CMD_TOT_LSB = 0;
  localparam int CMD_TX_LSB  = 8;
  localparam int CMD_HOLD    = 16;
  localparam int CMD_SEL_LSB = 20;

  typedef struct packed {
    logic [2:0]          spare_hi;
    logic [CLKDIV_W-1:0] divider;
    logic [3:0]          sel_en;
    logic                late_sel;
    logic                float_pins;
    logic [1:0]          gap_clks;
    logic                sel_active_hi;
    logic [1:0]          spare_lo;
    logic                lsb_first;
    logic                open_drain;
    logic                free_clock;
    logic                clk_idle_lo;
    logic                enable;
  } ctrl_word_t;

  typedef enum logic [1:0] {ST_IDLE, ST_SHIFT, ST_GAP} eng_state_t;

endpackage

// File: rtl/hdx_spi_clkgen.sv
module hdx_spi_clkgen #(
  parameter int DIV_W = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] divider,
  output logic             tick
);
  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] div_eff;

  assign div_eff = (divider == '0) ? DIV_W'(1) : divider;
  assign tick    = run && (cnt_q >= div_eff - DIV_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (!run)   cnt_q <= '0;
    else if (tick)   cnt_q <= '0;
    else             cnt_q <= cnt_q + DIV_W'(1);
  end

  // half periods longer than one cycle never produce back-to-back ticks
  assert_half_period_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && div_eff > DIV_W'(1) && $stable(divider)) |=> !tick);

endmodule

// File: rtl/hdx_spi_engine.sv
module hdx_spi_engine
  import hdx_spi_pkg::*;
#(
  parameter int NBYTES = 8,
  parameter int SEL_W  = 2,
  parameter int CNT_W  = 4,
  parameter int IDX_W  = 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  input  logic [CNT_W-1:0]      tot,
  input  logic [CNT_W-1:0]      txn,
  input  logic                  hold,
  input  logic [SEL_W-1:0]      sel,
  input  logic                  lsb_first,
  input  logic [1:0]            gap,
  input  logic                  tick,
  input  logic [NBYTES-1:0][7:0] buf_bytes,
  input  logic                  miso,
  output logic                  busy,
  output logic                  phase,
  output logic                  mosi,
  output logic                  sel_act,
  output logic [SEL_W-1:0]      sel_id,
  output logic                  rx_we,
  output logic [IDX_W-1:0]      rx_idx,
  output logic [7:0]            rx_data,
  output logic [CNT_W-1:0]      rxnum,
  output logic                  fin
);
  eng_state_t       state_q;
  logic [CNT_W-1:0] tot_q, txn_q, byte_q, rxn_q;
  logic [2:0]       bit_q, gap_q;
  logic [7:0]       txsh_q, rxsh_q;
  logic             phase_q, hold_q, lsb_q, act_q;
  logic [SEL_W-1:0] sel_q;
  logic             last_bit, last_byte, in_rx;
  logic [CNT_W-1:0] nxt;

  assign last_bit  = (bit_q == 3'd7);
  assign last_byte = (byte_q == tot_q - CNT_W'(1));
  assign in_rx     = (byte_q >= txn_q);
  assign nxt       = byte_q + CNT_W'(1);

  always_comb begin
    fin   = 1'b0;
    rx_we = 1'b0;
    case (state_q)
      ST_SHIFT: if (tick && phase_q && last_bit) begin
        rx_we = in_rx;
        fin   = last_byte && (gap_q == 3'd0);
      end
      ST_GAP: fin = (gap_q == 3'd0) || (tick && gap_q == 3'd1);
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      tot_q <= '0; txn_q <= '0; byte_q <= '0; rxn_q <= '0;
      bit_q <= '0; gap_q <= '0; txsh_q <= '0; rxsh_q <= '0;
      phase_q <= 1'b0; hold_q <= 1'b0; lsb_q <= 1'b0; act_q <= 1'b0;
      sel_q <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (start) begin
          tot_q   <= tot;
          txn_q   <= txn;
          hold_q  <= hold;
          lsb_q   <= lsb_first;
          sel_q   <= sel;
          gap_q   <= {gap, 1'b0};
          byte_q  <= '0;
          bit_q   <= '0;
          phase_q <= 1'b0;
          rxn_q   <= '0;
          txsh_q  <= buf_bytes[0];
          act_q   <= 1'b1;
          state_q <= (tot == '0) ? ST_GAP : ST_SHIFT;
        end
        ST_SHIFT: if (tick) begin
          if (!phase_q) begin
            phase_q <= 1'b1;
            rxsh_q  <= lsb_q ? {miso, rxsh_q[7:1]} : {rxsh_q[6:0], miso};
          end else begin
            phase_q <= 1'b0;
            if (last_bit) begin
              bit_q <= '0;
              if (in_rx) rxn_q <= rxn_q + CNT_W'(1);
              if (last_byte) begin
                act_q   <= hold_q;
                state_q <= (gap_q == 3'd0) ? ST_IDLE : ST_GAP;
              end else begin
                byte_q <= nxt;
                txsh_q <= buf_bytes[nxt[IDX_W-1:0]];
              end
            end else begin
              bit_q <= bit_q + 3'd1;
            end
          end
        end
        ST_GAP: begin
          if (fin) begin
            state_q <= ST_IDLE;
            act_q   <= hold_q;
          end else if (tick) begin
            gap_q <= gap_q - 3'd1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy    = (state_q != ST_IDLE);
  assign phase   = phase_q;
  assign mosi    = (state_q == ST_SHIFT) && !in_rx &&
                   txsh_q[lsb_q ? bit_q : (3'd7 - bit_q)];
  assign sel_act = act_q;
  assign sel_id  = sel_q;
  assign rx_idx  = byte_q[IDX_W-1:0];
  assign rx_data = rxsh_q;
  assign rxnum   = rxn_q;

  assert_release_sel_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (fin && !hold_q) |=> !sel_act);
  assert_rx_count_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(rxn_q) + int'(txn_q)) <= int'(tot_q));
  assert_clock_parked_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != ST_SHIFT) |-> !phase_q);
  assert_busy_cmd_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> (tot_q == $past(tot_q)) && (txn_q == $past(txn_q)));

endmodule

// File: rtl/hdx_spi_master.sv
module hdx_spi_master
  import hdx_spi_pkg::*;
#(
  parameter int NBYTES = 8,
  parameter int NUM_CS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [7:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              spi_sclk,
  output logic              spi_mosi,
  input  logic              spi_miso,
  output logic [NUM_CS-1:0] spi_cs,
  output logic              spi_oe,
  output logic              irq
);
  localparam int CNT_W     = $clog2(NBYTES + 1);
  localparam int IDX_W     = $clog2(NBYTES);
  localparam int SEL_W     = $clog2(NUM_CS);
  localparam int BUF_WORD0 = int'(ADR_BUF) / 8;

  ctrl_word_t             cfg_q;
  logic [NBYTES-1:0][7:0] buf_q;
  logic                   irq_q;
  logic                   wr_cfg, wr_stat, wr_cmd, wr_buf, buf_hit;
  logic [4:0]             word;
  logic [IDX_W-1:0]       buf_idx;
  logic [4:0]             f_tot, f_txn;
  logic [CNT_W-1:0]       tot_c, txn_c;
  logic                   busy, phase, sel_act, rx_we, fin, tick;
  logic [SEL_W-1:0]       sel_id;
  logic [IDX_W-1:0]       rx_idx;
  logic [7:0]             rx_data;
  logic [CNT_W-1:0]       rxnum;

  assign word    = reg_addr[7:3];
  assign buf_hit = (reg_addr[2:0] == 3'd0) && (int'(word) >= BUF_WORD0) &&
                   (int'(word) < BUF_WORD0 + NBYTES);
  assign buf_idx = IDX_W'(int'(word) - BUF_WORD0);
  assign wr_cfg  = reg_we && (reg_addr == ADR_CFG);
  assign wr_stat = reg_we && (reg_addr == ADR_STAT);
  assign wr_cmd  = reg_we && (reg_addr == ADR_CMD);
  assign wr_buf  = reg_we && buf_hit;

  assign f_tot = reg_wdata[CMD_TOT_LSB +: 5];
  assign f_txn = reg_wdata[CMD_TX_LSB +: 5];
  assign tot_c = (int'(f_tot) > NBYTES) ? CNT_W'(NBYTES) : CNT_W'(f_tot);
  assign txn_c = (int'(f_txn) > int'(tot_c)) ? tot_c : CNT_W'(f_txn);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cfg_q <= '0;
    else if (wr_cfg) cfg_q <= ctrl_word_t'(reg_wdata);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       irq_q <= 1'b0;
    else if (fin)                     irq_q <= 1'b1;
    else if (wr_stat && reg_wdata[1]) irq_q <= 1'b0;
  end

  for (genvar i = 0; i < NBYTES; i++) begin : g_buf
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                buf_q[i] <= '0;
      else if (rx_we && rx_idx == IDX_W'(i))     buf_q[i] <= rx_data;
      else if (wr_buf && buf_idx == IDX_W'(i))   buf_q[i] <= reg_wdata[7:0];
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == ADR_CFG) begin
      reg_rdata = cfg_q;
    end else if (reg_addr == ADR_STAT) begin
      reg_rdata[0]           = busy;
      reg_rdata[1]           = irq_q;
      reg_rdata[8 +: CNT_W]  = rxnum;
    end else if (buf_hit) begin
      reg_rdata[7:0] = buf_q[buf_idx];
    end
  end

  hdx_spi_clkgen #(.DIV_W(CLKDIV_W)) u_clkgen (
    .clk(clk), .rst_n(rst_n), .run(busy), .divider(cfg_q.divider), .tick(tick)
  );

  hdx_spi_engine #(.NBYTES(NBYTES), .SEL_W(SEL_W), .CNT_W(CNT_W), .IDX_W(IDX_W)) u_engine (
    .clk(clk), .rst_n(rst_n),
    .start(wr_cmd && cfg_q.enable),
    .tot(tot_c), .txn(txn_c),
    .hold(reg_wdata[CMD_HOLD]),
    .sel(reg_wdata[CMD_SEL_LSB +: SEL_W]),
    .lsb_first(cfg_q.lsb_first), .gap(cfg_q.gap_clks),
    .tick(tick), .buf_bytes(buf_q), .miso(spi_miso),
    .busy(busy), .phase(phase), .mosi(spi_mosi),
    .sel_act(sel_act), .sel_id(sel_id),
    .rx_we(rx_we), .rx_idx(rx_idx), .rx_data(rx_data),
    .rxnum(rxnum), .fin(fin)
  );

  assign spi_sclk = phase ^ ~cfg_q.clk_idle_lo;
  assign spi_oe   = cfg_q.enable;
  assign irq      = irq_q;

  for (genvar c = 0; c < NUM_CS; c++) begin : g_cs
    assign spi_cs[c] = (sel_act && sel_id == SEL_W'(c)) ? cfg_q.sel_active_hi
                                                         : ~cfg_q.sel_active_hi;
  end

  assert_busy_after_cmd_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_cmd && cfg_q.enable && !busy) |=> busy);
  assert_disabled_cmd_dropped_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_cmd && !cfg_q.enable && !busy) |=> !busy);
  assert_irq_on_finish_R9: assert property (@(posedge clk) disable iff (!rst_n)
    fin |=> irq);

endmodule

// File: tb/test_hdx_spi_master.sv
`timescale 1ns/1ps
module test_hdx_spi_master;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        spi_sclk, spi_mosi, spi_oe, irq;
  logic        spi_miso = 1'b0;
  logic [3:0]  spi_cs;

  always #2 clk = ~clk;

  hdx_spi_master i_hdx_spi_master (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .spi_sclk(spi_sclk),
    .spi_mosi(spi_mosi), .spi_miso(spi_miso), .spi_cs(spi_cs),
    .spi_oe(spi_oe), .irq(irq)
  );

  int   n_chk = 0, n_fail = 0;
  logic idle_lvl = 1'b1, prev_sclk = 1'b1, cs_ok = 1'b1;
  logic [3:0] cs_exp;
  int   cap_n = 0, ret_n = 0;
  logic cap_bits [0:127];
  logic miso_bits [0:127];

  // bench-side SPI device: captures on the leaving-idle edge, shifts on return
  always @(negedge clk) begin
    if (spi_sclk !== prev_sclk) begin
      if (prev_sclk == idle_lvl) begin
        if (cap_n < 128) cap_bits[cap_n] = spi_mosi;
        if (spi_cs !== cs_exp) cs_ok = 1'b0;
        cap_n++;
      end else begin
        ret_n++;
      end
    end
    prev_sclk = spi_sclk;
    spi_miso  = (ret_n < 128) ? miso_bits[ret_n] : 1'b0;
  end

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a; #1; d = reg_rdata;
  endtask

  function automatic int exp_busy(int t, int g, int dv);
    int n = 16 * t + 2 * g;
    int de = (dv == 0) ? 1 : dv;
    return (n == 0) ? 1 : n * de;
  endfunction

  // intrude: 0 none, 1 buffer write during shift (R10), 2 command write during shift (R8)
  task automatic run_cmd(input int tf, input int xf, input bit hold, input int sel,
                         input int gap, input int dv, input bit lsb, input bit ilo,
                         input bit chi, input int intrude);
    logic [7:0]  orig [8];
    logic [7:0]  rxp  [8];
    logic [31:0] d;
    int t, x, n, bad, pos;
    logic [7:0] newv, c, e;
    t = (tf > 8) ? 8 : tf;
    x = (xf > t) ? t : xf;
    wr(8'h00, 32'h1 | (32'(ilo) << 1) | (32'(lsb) << 4) | (32'(chi) << 7) |
              (32'(gap) << 8) | (32'(dv) << 16));
    idle_lvl = ~ilo;
    wr(8'h08, 32'h2);
    for (int k = 0; k < 8; k++) begin
      orig[k] = 8'($urandom); rxp[k] = 8'($urandom);
      wr(8'h80 + 8'(8 * k), {24'hABCDEF, orig[k]});
    end
    for (int k = 0; k < 8; k++)
      for (int j = 0; j < 8; j++) begin
        pos = lsb ? j : 7 - j;
        miso_bits[8 * k + j] = rxp[k][pos];
      end
    for (int b = 0; b < 4; b++) cs_exp[b] = (b == sel) ? chi : ~chi;
    repeat (2) @(negedge clk);
    cap_n = 0; ret_n = 0; cs_ok = 1'b1; prev_sclk = spi_sclk;
    newv = ~orig[0];
    wr(8'h10, 32'(tf) | (32'(xf) << 8) | (32'(hold) << 16) | (32'(sel) << 20));
    if (intrude == 1) wr(8'h80, {24'h0, newv});
    if (intrude == 2) wr(8'h10, 32'h0000_0008);
    reg_addr = 8'h08; #1;
    n = 0;
    while (reg_rdata[0]) begin n++; @(negedge clk); #1; end
    if (intrude == 0) chk("R3 busy length", n, exp_busy(t, gap, dv));
    chk("R6 pulse count", cap_n, 8 * t);
    chk("R6 clock parks at idle level", int'(spi_sclk), int'(idle_lvl));
    chk("R7 select asserted while shifting", int'(cs_ok), 1);
    bad = 0;
    for (int k = 0; k < t; k++) begin
      c = '0;
      for (int j = 0; j < 8; j++) begin
        pos = lsb ? j : 7 - j;
        c[pos] = cap_bits[8 * k + j];
      end
      e = (k < x) ? orig[k] : 8'h00;
      if (c !== e) bad++;
    end
    chk("R4 transmitted bytes", bad, 0);
    bad = 0;
    for (int k = 0; k < 8; k++) begin
      rd(8'h80 + 8'(8 * k), d);
      e = (k >= x && k < t) ? rxp[k] : orig[k];
      if (intrude == 1 && k == 0) chk("R10 buffer write while busy kept", int'(d), int'(newv));
      else if (d !== {24'h0, e}) bad++;
    end
    chk("R5 receive bytes in buffer", bad, 0);
    rd(8'h08, d);
    chk("R5 received count", int'(d[12:8]), t - x);
    chk("R9 completion flag", int'({d[1], irq}), 3);
    chk("R7 select after command", int'(spi_cs), hold ? int'(cs_exp) : (chi ? 0 : 15));
  endtask

  task automatic run_all();
    logic [31:0] d;
    void'($urandom(32'h5EED_1234));
    for (int k = 0; k < 128; k++) miso_bits[k] = 1'b0;
    cs_exp = 4'hF;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    prev_sclk = spi_sclk;
    // R1 reset state
    rd(8'h00, d); chk("R1 config resets to 0", int'(d), 0);
    rd(8'h08, d); chk("R1 status resets to 0", int'(d), 0);
    rd(8'h98, d); chk("R1 buffer resets to 0", int'(d), 0);
    chk("R1 outputs at reset", int'({spi_oe, irq, spi_cs}), 15);
    // R2 disabled command dropped
    wr(8'h10, 32'h0000_0404);
    rd(8'h08, d); chk("R2 command ignored while disabled", int'(d[0]), 0);
    chk("R2 no clock edges while disabled", cap_n, 0);
    wr(8'h00, 32'h1); #1;
    chk("R2 drive enable follows config", int'(spi_oe), 1);
    // directed corners
    run_cmd(8, 8, 0, 0, 0, 1, 0, 0, 0, 0);   // transmit only, MSB first
    run_cmd(4, 0, 0, 1, 1, 2, 0, 0, 0, 0);   // receive only
    run_cmd(13, 3, 0, 2, 0, 0, 1, 1, 1, 0);  // count limited, LSB first, idle low, active-high select
    run_cmd(2, 7, 1, 3, 3, 3, 0, 1, 0, 0);   // tx count above total, hold select
    run_cmd(0, 0, 0, 3, 0, 2, 0, 0, 0, 0);   // empty command
    run_cmd(2, 2, 0, 1, 0, 2, 0, 0, 0, 2);   // R8
    run_cmd(2, 2, 0, 0, 0, 2, 1, 0, 0, 1);   // R10
    // R9 clear
    wr(8'h08, 32'h2);
    rd(8'h08, d); chk("R9 flag cleared by write", int'({d[1], irq}), 0);
    // random sweep
    for (int r = 0; r < 30; r++)
      run_cmd(int'($urandom_range(12)), int'($urandom_range(10)), 1'($urandom),
              int'($urandom_range(3)), int'($urandom_range(3)), int'($urandom_range(3)),
              1'($urandom), 1'($urandom), 1'($urandom), 0);
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule